// File: doc/BRIEF.md
# Eight-Stage Shift Register with Asynchronous Jam Load

This block is a chain of eight single-bit storage stages with one serial input and one clock that all stages share. A mode input picks how data gets in. With the mode low, every rising clock edge moves the contents one stage toward the output end, and the serial input fills the first stage. With the mode high, eight jam inputs write straight into their own stages without waiting for a clock edge. The stages track those inputs for as long as the mode stays high, and clock edges do nothing in that time.

Three outputs are brought out: the last stage, which is also the serial output, and the two stages just before it. Longer registers are made by wiring the serial output of one instance to the serial input of the next. The stage contents are undefined at power-up until the first jam load or until eight shifts have filled every stage. The block has no reset, and the stream style with a handshake does not apply: data moves on every clock edge or on every change of the jam inputs, with no back-pressure.

Top module: `jam_shift_reg`

## Requirements
- R1: While `jam_en` is low, each rising edge of `clk` stores `ser_in` in stage 1 and copies every stage k into stage k+1.
- R2: While `jam_en` is high, stage i+1 equals `jam_d[i]` for every i from 0 to 7, with no clock edge needed. Stage 1 is at the serial-input end and stage 8 is at the output end.
- R3: While `jam_en` stays high, a change on any `jam_d` bit appears in its stage at once, between clock edges.
- R4: While `jam_en` is high, rising edges of `clk` do not change the stage contents.
- R5: When `jam_en` falls, the stages keep the last jam values until the next rising clock edge. Changes on `jam_d` after the fall have no effect.
- R6: `tap_s6` shows stage 6, `tap_s7` shows stage 7 and `ser_out` shows stage 8.
- R7: Two instances, with the first one's `ser_out` feeding the second one's `ser_in`, act as one sixteen-stage shift register.
- R8: After eight shifts, the contents depend only on the last eight serial bits. The oldest of those bits is at `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge, shared by all stages |
| jam_en | input | 1 | Mode: 0 = serial shift, 1 = asynchronous jam load |
| ser_in | input | 1 | Serial data into stage 1 |
| jam_d | input | 8 | Jam data; bit i drives stage i+1 |
| tap_s6 | output | 1 | Contents of stage 6 |
| tap_s7 | output | 1 | Contents of stage 7 |
| ser_out | output | 1 | Contents of stage 8, the serial output |

## Verification
The shift path is tested with alternating, all-ones and irregular serial streams after jam loads of contrasting values. Each stage shows up at the three outputs as it moves past them, so a swapped stage order or a stuck stage gives a wrong bit. Jams are asserted in the middle of a clock period and the jam data is then changed while the mode stays high, which tells a level-sensitive asynchronous load apart from an edge-sampled one. Changing the jam data after the mode falls separates holding the loaded value from following the inputs. A two-instance chain run through sixteen shifts shows that bits cross the boundary between instances in order.

// File: rtl/jamsr_pkg.sv
package jamsr_pkg;
  parameter int unsigned JSR_STAGES = 8;

  typedef enum logic {
    JSR_SHIFT = 1'b0,
    JSR_JAM   = 1'b1
  } jsr_mode_e;
endpackage

// File: rtl/jamsr_jam_dec.sv
// Turns the mode and the jam data into per-stage asynchronous set/clear strobes.
module jamsr_jam_dec #(
  parameter int unsigned W = 8
) (
  input  logic         load,
  input  logic [W-1:0] par,
  output logic [W-1:0] aset,
  output logic [W-1:0] aclr
);
  always_comb begin
    aset = {W{load}} & par;
    aclr = {W{load}} & ~par;
  end
endmodule

// File: rtl/jamsr_cell.sv
// One storage stage: rising-edge D with asynchronous set and clear.
module jamsr_cell (
  input  logic clk,
  input  logic aset,
  input  logic aclr,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge aset or posedge aclr) begin
    if (aclr)      q <= 1'b0;
    else if (aset) q <= 1'b1;
    else           q <= d;
  end

  // R2: the decoder must never ask for set and clear together
  always_comb begin
    a_r2_set_clr_excl: assert (!(aset && aclr));
  end
endmodule

// File: rtl/jam_shift_reg.sv
module jam_shift_reg
  import jamsr_pkg::*;
#(
  parameter int unsigned STAGES = JSR_STAGES
) (
  input  logic              clk,
  input  logic              jam_en,
  input  logic              ser_in,
  input  logic [STAGES-1:0] jam_d,
  output logic              tap_s6,
  output logic              tap_s7,
  output logic              ser_out
);
  localparam int unsigned LAST = STAGES - 1;

  jsr_mode_e         mode;
  logic [STAGES-1:0] aset;
  logic [STAGES-1:0] aclr;
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  assign mode = jsr_mode_e'(jam_en);

  jamsr_jam_dec #(.W(STAGES)) u_dec (
    .load (mode == JSR_JAM),
    .par  (jam_d),
    .aset (aset),
    .aclr (aclr)
  );

  assign stg_d = {stg_q[STAGES-2:0], ser_in};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    jamsr_cell u_cell (
      .clk  (clk),
      .aset (aset[k]),
      .aclr (aclr[k]),
      .d    (stg_d[k]),
      .q    (stg_q[k])
    );
  end

  assign tap_s6  = stg_q[LAST-2];
  assign tap_s7  = stg_q[LAST-1];
  assign ser_out = stg_q[LAST];

  // Assertion arming: $past is only meaningful after the first edge
  logic armed;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_head: assert property (@(posedge clk) disable iff (!armed || jam_en)
    !$past(jam_en) |-> stg_q[0] == $past(ser_in));

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    a_r1_shift: assert property (@(posedge clk) disable iff (!armed || jam_en)
      !$past(jam_en) |-> stg_q[k] == $past(stg_q[k-1]));
  end

  a_r2_jam_match: assert property (@(posedge clk) disable iff (!armed)
    jam_en |-> stg_q == jam_d);
endmodule

// File: tb/jam_shift_reg_tb.sv
module jam_shift_reg_tb;
  logic       clk = 1'b0;
  logic       jam_a = 1'b1, jam_b = 1'b1, ser_a = 1'b0;
  logic [7:0] jd_a = 8'h00, jd_b = 8'h00;
  logic       t6_a, t7_a, so_a, t6_b, t7_b, so_b;
  logic [7:0] mA = 8'h00, mB = 8'h00;
  int         n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  jam_shift_reg u_dut (.clk(clk), .jam_en(jam_a), .ser_in(ser_a), .jam_d(jd_a),
                       .tap_s6(t6_a), .tap_s7(t7_a), .ser_out(so_a));
  jam_shift_reg u_dut_b (.clk(clk), .jam_en(jam_b), .ser_in(so_a), .jam_d(jd_b),
                         .tap_s6(t6_b), .tap_s7(t7_b), .ser_out(so_b));

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic chk_a(string tag);
    chk(tag, {t6_a, t7_a, so_a}, {mA[5], mA[6], mA[7]});
  endtask

  task automatic chk_b(string tag);
    chk(tag, {t6_b, t7_b, so_b}, {mB[5], mB[6], mB[7]});
  endtask

  // one clock edge with jam low; call at posedge+2, returns at posedge+2
  task automatic step(logic s, bit with_b, string tag);
    ser_a = s;
    @(posedge clk);
    if (with_b) mB = {mB[6:0], mA[7]};
    mA = {mA[6:0], s};
    #2;
    chk_a(tag);
    if (with_b) chk_b({tag, "_chainB"});
  endtask

  task automatic to_mid_high();
    @(posedge clk); #2;
  endtask

  // R2 and R6: mid-period jam of several patterns
  task automatic t_jam();
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hE0, 8'h1F};
    foreach (pats[i]) begin
      @(negedge clk); #1;
      jam_a = 1'b0; jd_a = ~pats[i];
      #1; jd_a = pats[i]; jam_a = 1'b1; mA = pats[i];
      #1; chk_a("R2_R6_jam_midperiod");
    end
  endtask

  // R3 and R4: follow while high, clock edges ignored
  task automatic t_follow();
    jam_a = 1'b1;
    @(negedge clk); #1;
    jd_a = 8'h40; mA = 8'h40; #1; chk_a("R3_follow_s7");
    jd_a = 8'hC0; mA = 8'hC0; #1; chk_a("R3_follow_s8");
    jd_a = 8'h20; mA = 8'h20; #1; chk_a("R3_follow_s6");
    ser_a = 1'b1;
    repeat (3) @(posedge clk);
    #2; chk_a("R4_edges_ignored");
    jd_a = 8'hE0; mA = 8'hE0; #1; chk_a("R3_follow_after_edges");
  endtask

  // R5: release, change jam data, hold until edge, then shift
  task automatic t_release();
    jam_a = 1'b1; jd_a = 8'h60; mA = 8'h60;
    to_mid_high();
    jam_a = 1'b0; #1;
    jd_a = 8'h9F; #1;
    chk_a("R5_hold_after_fall");
    step(1'b0, 1'b0, "R5_first_shift");
    step(1'b0, 1'b0, "R5_second_shift");
    jam_a = 1'b1; jd_a = 8'h00; mA = 8'h00;
  endtask

  // R1 and R8: serial streams after contrasting loads
  task automatic t_serial(logic [7:0] init, logic [15:0] bits, string tag);
    jam_a = 1'b1; jd_a = init; mA = init;
    to_mid_high();
    jam_a = 1'b0;
    for (int i = 0; i < 16; i++) step(bits[i], 1'b0, {"R1_", tag});
    chk(tag == "" ? "R8" : "R8_fill", {so_a, t7_a, t6_a}, {bits[8], bits[9], bits[10]});
    jam_a = 1'b1; jd_a = 8'h00; mA = 8'h00;
  endtask

  // R7: two-register chain
  task automatic t_chain();
    jam_a = 1'b1; jam_b = 1'b1;
    jd_a = 8'hC3; jd_b = 8'h81; mA = 8'hC3; mB = 8'h81;
    to_mid_high();
    chk_b("R7_chainB_loaded");
    jam_a = 1'b0; jam_b = 1'b0;
    for (int i = 0; i < 16; i++) step(logic'(i % 3 == 0), 1'b1, "R7_chain");
    jam_a = 1'b1; jam_b = 1'b1; jd_a = 8'h00; jd_b = 8'h00; mA = 8'h00; mB = 8'h00;
  endtask

  bit done = 1'b0;

  initial begin
    #1;
    chk_a("R2_initial_jam_zero");
    t_jam();
    t_follow();
    t_release();
    t_serial(8'h00, 16'hAAAA, "alt");
    t_serial(8'hFF, 16'h0000, "zeros");
    t_serial(8'h00, 16'hFFFF, "ones");
    t_serial(8'hA5, 16'h3C96, "mixed");
    t_chain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule